// File: doc/BRIEF.md
# Round-Robin Channel Command Sequencer

This block holds one stored sample for each of eight output channels and turns them, one at a time, into 16-bit command words for a channel-addressed output device. Every word carries three fields. The top bit is an enable flag that is always set. The next three bits give the channel index, where index 0 means the first channel. The low twelve bits hold the sample. A host fills the eight-entry table through a simple write port. The block then walks the channels in a fixed rotating order and presents each word on a valid/ready output.

In normal mode, each update tick sends exactly one word, so every channel is refreshed once in eight ticks. In burst mode, a single tick sends all eight words back to back. A mode input selects how table entries are read. They can be plain binary, or four packed decimal digits that the block converts to binary before masking. A malformed decimal entry is flagged and its sample is sent as zero.

The channel pointer is one-hot. A pointer that is not one-hot is read as the first channel and repaired, so the rotation always restarts cleanly at channel 1. The outgoing word is captured into a register when it is issued. Table writes therefore never disturb a word that is waiting for acceptance.

Top module: `rrseq_top`

## Requirements
- R1: After reset, cmd_valid_o is low, cmd_word_o and cmd_err_o are zero, every table entry is zero, and the first word issued carries channel index 0 in bits 14:12.
- R2: Every issued word has bit 15 set, bits 14:12 equal to the channel index, and bits 11:0 equal to the sample.
- R3: With bcd_mode_i low, the sample is bits 11:0 of the table entry, and bits 15:12 of the entry are discarded.
- R4: In normal mode, a tick while idle issues exactly one word. The index advances by one only when that word is accepted, and it wraps from 7 to 0.
- R5: With bcd_mode_i high, the entry is read as four decimal digits, bits 15:12 being the thousands digit and bits 3:0 the units digit. Its value is converted to binary, and the sample is the low 12 bits of the result.
- R6: With bcd_mode_i high, any digit above 9 makes cmd_err_o high alongside that word, and the word's sample field is 0.
- R7: A tick with burst_i high issues eight words, starting at the current index and increasing modulo 8. With cmd_ready_i held high they appear on consecutive cycles, and the index ends where it started.
- R8: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high, cmd_word_o and cmd_err_o hold, and the index does not move.
- R9: A table write to the entry of a word that is already issued does not change that word; the new value appears on the channel's next pass.
- R10: A tick that arrives while a word or a burst is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Update request, one cycle |
| burst_i | input | 1 | With tick_i: send all eight channels |
| bcd_mode_i | input | 1 | Table entries are packed decimal digits |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 3 | Table entry to write |
| wr_data_i | input | 16 | Table write data |
| cmd_ready_i | input | 1 | Receiver accepts the current word |
| cmd_valid_o | output | 1 | Command word is present |
| cmd_word_o | output | 16 | Enable bit, channel index and sample |
| cmd_err_o | output | 1 | Decimal entry of this word held a digit above 9 |

## Verification
The main function is driven with binary entries whose upper nibbles are set, which separates correct masking from a leak into the index or enable fields. It is also driven with decimal entries chosen so that a missing conversion, a missing mask of a large decimal value (9999), or a missed invalid digit each give a different word. The rotation is checked over nine single ticks, so the 7-to-0 wrap is seen. A burst is checked starting from a middle index, so a burst that wrongly restarts at channel 1 is caught. A held, unaccepted word is combined with a write to its own entry and an extra tick, which separates a captured word from a live table read and shows that the stray tick was dropped. A reset in the middle of a run then shows the restart at channel 1 with a cleared table.

// File: rtl/rrseq_pkg.sv
package rrseq_pkg;

  // Default geometry shared by every level of the sequencer.
  parameter int unsigned SEQ_N_CH   = 8;
  parameter int unsigned SEQ_WORD_W = 16;
  parameter int unsigned SEQ_DATA_W = 12;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rrseq_table.sv
module rrseq_table #(
  parameter int unsigned N_CH   = rrseq_pkg::SEQ_N_CH,
  parameter int unsigned WORD_W = rrseq_pkg::SEQ_WORD_W,
  localparam int unsigned AW    = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] mem_q [N_CH];
  logic [N_CH-1:0]   wr_hit;

  // Per-entry clock enables.
  always_comb begin
    for (int e = 0; e < N_CH; e++) begin
      wr_hit[e] = wr_en_i && (wr_addr_i == AW'(e));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_CH; e++) begin
        mem_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_CH; e++) begin
        if (wr_hit[e]) begin
          mem_q[e] <= wr_data_i;
        end
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

endmodule

// File: rtl/rrseq_fmt.sv
module rrseq_fmt #(
  parameter int unsigned N_CH   = rrseq_pkg::SEQ_N_CH,
  parameter int unsigned WORD_W = rrseq_pkg::SEQ_WORD_W,
  parameter int unsigned DATA_W = rrseq_pkg::SEQ_DATA_W,
  parameter bit          BCD_EN = 1'b1,
  localparam int unsigned AW    = $clog2(N_CH)
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic [AW-1:0]     idx_i,
  input  logic              bcd_mode_i,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);

  localparam int unsigned DIGITS = WORD_W / 4;
  localparam logic [WORD_W-1:0] DATA_MASK = WORD_W'((1 << DATA_W) - 1);
  localparam logic [WORD_W-1:0] EN_BIT    = WORD_W'(1) << (WORD_W - 1);

  logic [WORD_W-1:0] conv_w;
  logic              bad_w;
  logic [WORD_W-1:0] sel_w;
  logic [WORD_W-1:0] masked_w;

  generate
    if (BCD_EN) begin : g_bcd
      logic [WORD_W-1:0] acc;
      logic [3:0]        nib;
      logic              bad;
      // Horner evaluation: most significant digit first.
      always_comb begin
        acc = '0;
        bad = 1'b0;
        nib = '0;
        for (int d = DIGITS - 1; d >= 0; d--) begin
          nib = raw_i[d*4 +: 4];
          bad = bad | (nib > 4'd9);
          acc = WORD_W'(acc * WORD_W'(10)) + WORD_W'(nib);
        end
      end
      assign conv_w = acc;
      assign bad_w  = bcd_mode_i && bad;
    end else begin : g_bin
      assign conv_w = raw_i;
      assign bad_w  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (bcd_mode_i && BCD_EN) begin
      sel_w = bad_w ? '0 : conv_w;
    end else begin
      sel_w = raw_i;
    end
    masked_w = sel_w & DATA_MASK;
    word_o   = EN_BIT | (WORD_W'(idx_i) << DATA_W) | masked_w;
    err_o    = bad_w;
  end

endmodule

// File: rtl/rrseq_ctrl.sv
module rrseq_ctrl
  import rrseq_pkg::*;
#(
  parameter int unsigned N_CH   = rrseq_pkg::SEQ_N_CH,
  parameter int unsigned WORD_W = rrseq_pkg::SEQ_WORD_W,
  parameter int unsigned DATA_W = rrseq_pkg::SEQ_DATA_W,
  localparam int unsigned AW    = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              burst_i,
  input  logic              ready_i,
  input  logic [WORD_W-1:0] fmt_word_i,
  input  logic              fmt_err_i,
  output logic [AW-1:0]     rd_idx_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);

  function automatic logic [AW-1:0] f_enc(input logic [N_CH-1:0] oh);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (oh[i]) r = r | AW'(i);
    end
    return r;
  endfunction

  seq_state_e        st_q, st_d;
  logic [N_CH-1:0]   ptr_q, ptr_d, ptr_cur, ptr_nxt, ptr_sel;
  logic [AW-1:0]     left_q, left_d;
  logic [WORD_W-1:0] word_q;
  logic              err_q;
  logic              accept, start, chain, load, ptr_en, left_en;

  // Next-state logic
  always_comb begin
    ptr_cur = $onehot(ptr_q) ? ptr_q : N_CH'(1);
    ptr_nxt = {ptr_cur[N_CH-2:0], ptr_cur[N_CH-1]};
    accept  = (st_q == ST_SEND) && ready_i;
    start   = (st_q == ST_IDLE) && tick_i;
    chain   = accept && (left_q != '0);
    load    = start || chain;
    ptr_sel = accept ? ptr_nxt : ptr_cur;

    st_d   = st_q;
    left_d = left_q;
    if (start) begin
      st_d   = ST_SEND;
      left_d = burst_i ? AW'(N_CH - 1) : '0;
    end else if (accept) begin
      if (left_q == '0) st_d = ST_IDLE;
      else              left_d = left_q - AW'(1);
    end
    left_en = start || chain;

    ptr_d  = accept ? ptr_nxt : ptr_cur;
    ptr_en = accept || !$onehot(ptr_q);
  end

  assign rd_idx_o = f_enc(ptr_sel);

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= N_CH'(1);
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      word_q <= fmt_word_i;
      err_q  <= fmt_err_i;
    end
  end

  assign valid_o = (st_q == ST_SEND);
  assign word_o  = word_q;
  assign err_o   = err_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o) && $stable(err_o) && $stable(ptr_q)));

  // R2
  field_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (word_o[WORD_W-1] && (word_o[DATA_W +: AW] == f_enc(ptr_q))));

  // R4
  ptr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ptr_q));

  // R4
  advance_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> (ptr_q != $past(ptr_q)));

  // R10
  start_from_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(tick_i));

  // R6
  err_zero_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (word_o[DATA_W-1:0] == '0));

  // R7
  burst_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0) |-> valid_o);

endmodule

// File: rtl/rrseq_top.sv
module rrseq_top #(
  parameter int unsigned N_CH   = rrseq_pkg::SEQ_N_CH,
  parameter int unsigned WORD_W = rrseq_pkg::SEQ_WORD_W,
  parameter int unsigned DATA_W = rrseq_pkg::SEQ_DATA_W,
  parameter bit          BCD_EN = 1'b1,
  localparam int unsigned AW    = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              burst_i,
  input  logic              bcd_mode_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              cmd_ready_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_err_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [AW-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] fmt_word;
  logic              fmt_err;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  rrseq_table #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  rrseq_fmt #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W),
    .DATA_W (DATA_W),
    .BCD_EN (BCD_EN)
  ) u_fmt (
    .raw_i      (rd_data),
    .idx_i      (rd_idx),
    .bcd_mode_i (bcd_mode_i),
    .word_o     (fmt_word),
    .err_o      (fmt_err)
  );

  rrseq_ctrl #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tick_i     (tick_i),
    .burst_i    (burst_i),
    .ready_i    (cmd_ready_i),
    .fmt_word_i (fmt_word),
    .fmt_err_i  (fmt_err),
    .rd_idx_o   (rd_idx),
    .valid_o    (cmd_valid_o),
    .word_o     (cmd_word_o),
    .err_o      (cmd_err_o)
  );

endmodule

// File: tb/rrseq_top_tb.sv
module rrseq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, burst, bcd_mode, wr_en, cmd_ready;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        cmd_valid, cmd_err;
  logic [15:0] cmd_word;

  always #10 clk = ~clk;

  rrseq_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .burst_i     (burst),
    .bcd_mode_i  (bcd_mode),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .cmd_ready_i (cmd_ready),
    .cmd_valid_o (cmd_valid),
    .cmd_word_o  (cmd_word),
    .cmd_err_o   (cmd_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] tbl [8];
  logic [15:0] got_w [64];
  logic        got_e [64];
  int          got_c [64];
  int          n_got = 0;

  always @(posedge clk) cyc++;

  // Record each accepted word, sampled mid-way between edges.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (n_got < 64) begin
        got_w[n_got] = cmd_word;
        got_e[n_got] = cmd_err;
        got_c[n_got] = cyc;
      end
      n_got++;
    end
  end

  function automatic logic [15:0] expw(input int idx, input logic [15:0] s);
    return 16'h8000 | (16'(idx) << 12) | (s & 16'h0FFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick(input logic b);
    @(negedge clk);
    tick = 1'b1; burst = b;
    @(negedge clk);
    tick = 1'b0; burst = 1'b0;
  endtask

  task automatic wait_got(input int n);
    for (int i = 0; i < 60 && n_got < n; i++) begin
      @(negedge clk);
      #6;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #6;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    idle(3);
    chk("R1 valid in reset", 32'(cmd_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 valid after reset", 32'(cmd_valid), 32'h0);
    chk("R1 word after reset", 32'(cmd_word), 32'h0);
    chk("R1 err after reset", 32'(cmd_err), 32'h0);
  endtask

  task automatic t_normal_rotation();
    for (int e = 0; e < 8; e++) tbl[e] = 16'h0123 + 16'(e) * 16'h0111;
    tbl[3] = 16'h7FFF;
    tbl[5] = 16'hFEDC;
    for (int e = 0; e < 8; e++) wr(e, tbl[e]);
    cmd_ready = 1'b1;
    for (int k = 0; k < 9; k++) begin
      n_got = 0;
      pulse_tick(1'b0);
      wait_got(1);
      idle(3);
      chk("R4 one word per tick", 32'(n_got), 32'd1);
      chk("R2 R3 R4 word in rotation", 32'(got_w[0]), 32'(expw(k % 8, tbl[k % 8])));
      chk("R3 no error in binary mode", 32'(got_e[0]), 32'h0);
    end
  endtask

  task automatic t_bcd();
    // Index is now 1.
    bcd_mode = 1'b1;
    wr(1, 16'h2345);
    wr(2, 16'h9999);
    wr(3, 16'h12A4);
    wr(4, 16'h4095);
    n_got = 0;
    for (int k = 0; k < 4; k++) begin
      pulse_tick(1'b0);
      wait_got(k + 1);
    end
    idle(2);
    chk("R5 decimal 2345", 32'(got_w[0]), 32'h9929);
    chk("R5 decimal 9999 masked", 32'(got_w[1]), 32'hA70F);
    chk("R5 no error on 9999", 32'(got_e[1]), 32'h0);
    chk("R6 bad digit word", 32'(got_w[2]), 32'hB000);
    chk("R6 bad digit flag", 32'(got_e[2]), 32'h1);
    chk("R5 decimal 4095", 32'(got_w[3]), 32'hCFFF);
    chk("R6 flag clears", 32'(got_e[3]), 32'h0);
    bcd_mode = 1'b0;
  endtask

  task automatic t_burst();
    // Index is now 5.
    for (int e = 0; e < 8; e++) begin
      tbl[e] = 16'h0A00 + 16'(e);
      wr(e, tbl[e]);
    end
    n_got = 0;
    pulse_tick(1'b1);
    wait_got(8);
    idle(4);
    chk("R7 burst count", 32'(n_got), 32'd8);
    for (int k = 0; k < 8; k++) begin
      chk("R7 burst word", 32'(got_w[k]), 32'(expw((5 + k) % 8, tbl[(5 + k) % 8])));
      if (k > 0) chk("R7 burst back to back", 32'(got_c[k] - got_c[k-1]), 32'd1);
    end
    chk("R7 idle after burst", 32'(cmd_valid), 32'h0);
  endtask

  task automatic t_hold_and_write();
    logic [15:0] w0;
    // Index is back at 5.
    cmd_ready = 1'b0;
    n_got = 0;
    pulse_tick(1'b0);
    idle(1);
    w0 = cmd_word;
    chk("R8 held word value", 32'(w0), 32'(expw(5, tbl[5])));
    wr(5, 16'h0ABC);
    pulse_tick(1'b0);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      chk("R8 valid held", 32'(cmd_valid), 32'h1);
      chk("R9 held word unchanged by write", 32'(cmd_word), 32'(w0));
    end
    @(negedge clk);
    cmd_ready = 1'b1;
    wait_got(1);
    idle(6);
    chk("R10 extra tick ignored", 32'(n_got), 32'd1);
    chk("R8 accepted word", 32'(got_w[0]), 32'(w0));
    chk("R10 idle after single word", 32'(cmd_valid), 32'h0);
    // Index is 6; the burst reaches entry 5 last.
    n_got = 0;
    pulse_tick(1'b1);
    wait_got(8);
    idle(2);
    chk("R7 burst starts at current index", 32'(got_w[0]), 32'(expw(6, tbl[6])));
    chk("R9 new value on next pass", 32'(got_w[7]), 32'(expw(5, 16'h0ABC)));
  endtask

  task automatic t_reset_restart();
    n_got = 0;
    pulse_tick(1'b0);
    wait_got(1);
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk("R1 valid low after mid-run reset", 32'(cmd_valid), 32'h0);
    n_got = 0;
    pulse_tick(1'b0);
    wait_got(1);
    chk("R1 restart at channel 1, table cleared", 32'(got_w[0]), 32'h8000);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; burst = 1'b0; bcd_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; cmd_ready = 1'b0;
    t_reset_state();
    t_normal_rotation();
    t_bcd();
    t_burst();
    t_hold_and_write();
    t_reset_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule